// File: doc/BRIEF.md
# Coalescing Log Replay Engine

This engine empties a redo log into main memory when the controller's address-mapping table has no free slot. It reads the log records from the newest to the oldest and builds a small temporary index. The index keeps one line per address and a byte mask of the bytes already claimed, so an older record can fill only bytes that no newer committed record has written. Records from transactions that have not committed are skipped. When the scan is over, each indexed line is written to its home address with its byte mask. The matching mapping-table entry is invalidated once the memory acknowledges the write.

From the accepted start until the final status pulse, the engine holds a lock output. The memory controller uses the lock to divert cache write-backs into its eviction buffer. If the scan finds no committed record, nothing is written, the lock drops and an abort pulse tells the controller that the running transaction must be abandoned. Replay depends only on the log contents. A second pass over the same log therefore produces the same sequence of home writes and leaves the same home image.

The log read port has a fixed latency of one cycle. The engine presents a record index, and the record fields must be valid in the following cycle.

Top module: `coalescing_replay_engine`

## Requirements
- R1: A pass starts only when `start_i` and `table_full_i` are both high while the engine is idle. A `start_i` pulse while `table_full_i` is low is ignored: no lock, no log read and no status pulse follows.
- R2: `lock_o` goes high in the cycle after an accepted start. It stays high until the cycle in which `done_o` or `abort_o` pulses, and is low in that cycle.
- R3: Log records are read one per cycle with `rd_idx_o` running from `log_count_i`-1 down to 0. Index 0 is the oldest record. A record's fields are taken from the `rd_*` inputs in the cycle after `rd_en_o`.
- R4: For each address, each byte of the home write holds the value from the newest committed record that wrote that byte. Byte b of the line lies at bits [8b+7:8b] and is enabled by mask bit b. `hw_mask_o` is the union of the committed masks for the address, and bytes outside it are driven as zero.
- R5: A record with `rd_commit_i` low contributes nothing. An address that appears only in such records gets neither a home write nor an invalidate.
- R6: Home writes are issued one at a time, one per indexed address, in the order in which the newest-first scan first met each address. `hw_valid_o`, `hw_addr_o`, `hw_mask_o` and `hw_data_o` hold steady until the cycle in which `hw_ack_i` is high.
- R7: In the cycle after each acknowledged home write, `inv_valid_o` pulses for one cycle with `inv_addr_o` equal to the address that was written.
- R8: `done_o` pulses for one cycle, in the cycle after the last home write is acknowledged.
- R9: If the log holds no committed record, including an empty log, no home write is issued and `abort_o` pulses for one cycle instead of `done_o`.
- R10: The index holds 16 addresses. A committed record whose address is not yet indexed while the index is full is skipped, and that address gets no write and no invalidate.
- R11: Running a second pass over an unchanged log gives exactly the same sequence of home writes as the first pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a replay pass |
| table_full_i | input | 1 | Mapping table has no free entry |
| log_count_i | input | 6 | Number of records in the log |
| rd_en_o | output | 1 | Log record read request |
| rd_idx_o | output | 5 | Index of the record requested |
| rd_addr_i | input | 16 | Home line address of the returned record |
| rd_mask_i | input | 8 | Byte mask of the returned record |
| rd_data_i | input | 64 | Byte data of the returned record |
| rd_commit_i | input | 1 | Returned record belongs to a committed transaction |
| hw_valid_o | output | 1 | Home write pending |
| hw_addr_o | output | 16 | Home write line address |
| hw_mask_o | output | 8 | Home write byte enables |
| hw_data_o | output | 64 | Home write data |
| hw_ack_i | input | 1 | Home write accepted |
| inv_valid_o | output | 1 | Invalidate one mapping-table entry |
| inv_addr_o | output | 16 | Address whose mapping entry is removed |
| lock_o | output | 1 | Divert cache write-backs to the eviction buffer |
| done_o | output | 1 | Pass completed |
| abort_o | output | 1 | No committed work; running transaction must abort |

## Verification
The log read port answers `rd_en_o` one cycle later, and the bench checks each requested index against a descending expectation when it is requested. Each home write is compared with the head of a queue of expected lines when it is accepted, that is, in the cycle where valid and acknowledge meet. The invalidate for that line is checked exactly one cycle later. `done_o` or `abort_o` is due one cycle after the last accept or after the scan drains, and the lock is checked low in that same cycle. The acknowledge delay is varied between passes so that holding the write steady is exercised across several waits.

// File: rtl/lre_pkg.sv
// Package: shared types for the coalescing log replay engine.
// Assumes: nothing beyond IEEE 1800-2017.
package lre_pkg;

    // Pass sequencing states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_WRITE = 2'd2
    } lre_state_t;

endpackage

// File: rtl/lre_match.sv
// Module: lre_match
// Compares one address with every occupied index slot and returns the
// lowest matching slot. Assumes each address occupies at most one slot.
module lre_match #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 16,
    localparam int PTR_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             slot_valid_i,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] slot_addr_i,
    input  logic [ADDR_W-1:0]              key_i,
    output logic                           hit_o,
    output logic [PTR_W-1:0]               hit_idx_o
);

    logic [ENTRIES-1:0] eq;

    // One comparator per slot
    for (genvar s = 0; s < ENTRIES; s++) begin : g_cmp
        assign eq[s] = slot_valid_i[s] && (slot_addr_i[s] == key_i);
    end

    // Encode the lowest matching slot
    always_comb begin
        hit_o     = |eq;
        hit_idx_o = '0;
        for (int s = ENTRIES - 1; s >= 0; s--) begin
            if (eq[s]) hit_idx_o = PTR_W'(s);
        end
    end

endmodule

// File: rtl/lre_index.sv
// Module: lre_index
// Temporary coalescing index. Each slot holds one line address, a byte
// mask of claimed bytes and the line data. Updates arrive newest first,
// so a hit fills only bytes that are not yet claimed. A new address takes
// the next free slot, and is dropped when the index is full.
// Assumes: clear_i and upd_i are never high together.
module lre_index #(
    parameter int ENTRIES    = 16,
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 8,
    localparam int PTR_W     = $clog2(ENTRIES),
    localparam int CNT_W     = $clog2(ENTRIES + 1),
    localparam int DATA_W    = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  upd_i,
    input  logic [ADDR_W-1:0]     upd_addr_i,
    input  logic [LINE_BYTES-1:0] upd_mask_i,
    input  logic [DATA_W-1:0]     upd_data_i,
    input  logic [PTR_W-1:0]      sel_i,
    output logic [ADDR_W-1:0]     sel_addr_o,
    output logic [LINE_BYTES-1:0] sel_mask_o,
    output logic [DATA_W-1:0]     sel_data_o,
    output logic [CNT_W-1:0]      count_o
);

    logic [ENTRIES-1:0]                 valid_q;
    logic [ENTRIES-1:0][ADDR_W-1:0]     addr_q;
    logic [ENTRIES-1:0][LINE_BYTES-1:0] mask_q;
    logic [ENTRIES-1:0][DATA_W-1:0]     data_q;
    logic [CNT_W-1:0]                   count_q;
    logic                               hit;
    logic [PTR_W-1:0]                   hit_idx;
    logic [PTR_W-1:0]                   free_slot;
    logic                               has_room;
    logic [DATA_W-1:0]                  masked_data;

    lre_match #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W)
    ) u_match (
        .slot_valid_i (valid_q),
        .slot_addr_i  (addr_q),
        .key_i        (upd_addr_i),
        .hit_o        (hit),
        .hit_idx_o    (hit_idx)
    );

    // Derive the free slot and zero unwritten bytes of an incoming record
    always_comb begin
        free_slot = count_q[PTR_W-1:0];
        has_room  = count_q < CNT_W'(ENTRIES);
        for (int b = 0; b < LINE_BYTES; b++) begin
            masked_data[b*8 +: 8] = upd_mask_i[b] ? upd_data_i[b*8 +: 8] : 8'h00;
        end
    end

    // Slot storage: clear, merge into a hit, or allocate
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            count_q <= '0;
            valid_q <= '0;
            mask_q  <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (upd_i) begin
            if (hit) begin
                for (int b = 0; b < LINE_BYTES; b++) begin
                    if (upd_mask_i[b] && !mask_q[hit_idx][b]) begin
                        data_q[hit_idx][b*8 +: 8] <= upd_data_i[b*8 +: 8];
                    end
                end
                mask_q[hit_idx] <= mask_q[hit_idx] | upd_mask_i;
            end else if (has_room) begin
                valid_q[free_slot] <= 1'b1;
                addr_q[free_slot]  <= upd_addr_i;
                mask_q[free_slot]  <= upd_mask_i;
                data_q[free_slot]  <= masked_data;
                count_q            <= count_q + CNT_W'(1);
            end
        end
    end

    assign sel_addr_o = addr_q[sel_i];
    assign sel_mask_o = mask_q[sel_i];
    assign sel_data_o = data_q[sel_i];
    assign count_o    = count_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(ENTRIES)); // R10

    AST_CLAIMED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && hit) |=> ((mask_q[$past(hit_idx)] & $past(mask_q[hit_idx])) == $past(mask_q[hit_idx]))); // R4

endmodule

// File: rtl/lre_ctrl.sv
// Module: lre_ctrl
// Sequences a replay pass. It accepts a start, walks the log from the
// newest record down, then issues one home write per index slot, waits
// for each acknowledge, invalidates the mapping entry and finally pulses
// done or abort. Assumes the log read port has one cycle of latency.
module lre_ctrl
    import lre_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 16,
    parameter int LOG_AW  = 5,
    localparam int PTR_W  = $clog2(ENTRIES),
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              table_full_i,
    input  logic [LOG_AW:0]   log_count_i,
    output logic              rd_en_o,
    output logic [LOG_AW-1:0] rd_idx_o,
    output logic              rec_pending_o,
    output logic              idx_clear_o,
    input  logic [CNT_W-1:0]  idx_count_i,
    output logic [PTR_W-1:0]  wptr_o,
    input  logic [ADDR_W-1:0] cur_addr_i,
    output logic              hw_valid_o,
    input  logic              hw_ack_i,
    output logic              inv_valid_o,
    output logic [ADDR_W-1:0] inv_addr_o,
    output logic              lock_o,
    output logic              done_o,
    output logic              abort_o
);

    lre_state_t        state_q;
    logic [LOG_AW:0]   cursor_q;
    logic [LOG_AW:0]   cursor_m1;
    logic              pending_q;
    logic [PTR_W-1:0]  wptr_q;
    logic              last_slot;
    logic              accept;
    logic              scan_drained;

    // Decode strobes from the current state
    always_comb begin
        accept       = (state_q == ST_IDLE) && start_i && table_full_i;
        cursor_m1    = cursor_q - (LOG_AW + 1)'(1);
        rd_en_o      = (state_q == ST_SCAN) && (cursor_q != '0);
        rd_idx_o     = cursor_m1[LOG_AW-1:0];
        scan_drained = (state_q == ST_SCAN) && (cursor_q == '0) && !pending_q;
        last_slot    = (CNT_W'(wptr_q) + CNT_W'(1)) == idx_count_i;
    end

    // Pass state machine with the status and invalidate pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cursor_q    <= '0;
            pending_q   <= 1'b0;
            wptr_q      <= '0;
            done_o      <= 1'b0;
            abort_o     <= 1'b0;
            inv_valid_o <= 1'b0;
            inv_addr_o  <= '0;
        end else begin
            done_o      <= 1'b0;
            abort_o     <= 1'b0;
            inv_valid_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q   <= ST_SCAN;
                        cursor_q  <= log_count_i;
                        pending_q <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    pending_q <= rd_en_o;
                    if (rd_en_o) cursor_q <= cursor_m1;
                    if (scan_drained) begin
                        if (idx_count_i == '0) begin
                            state_q <= ST_IDLE;
                            abort_o <= 1'b1;
                        end else begin
                            state_q <= ST_WRITE;
                            wptr_q  <= '0;
                        end
                    end
                end
                ST_WRITE: begin
                    if (hw_ack_i) begin
                        inv_valid_o <= 1'b1;
                        inv_addr_o  <= cur_addr_i;
                        if (last_slot) begin
                            state_q <= ST_IDLE;
                            done_o  <= 1'b1;
                        end else begin
                            wptr_q <= wptr_q + PTR_W'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rec_pending_o = pending_q;
    assign idx_clear_o   = accept;
    assign wptr_o        = wptr_q;
    assign hw_valid_o    = (state_q == ST_WRITE);
    assign lock_o        = (state_q != ST_IDLE);

    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(start_i && table_full_i)); // R1

    AST_READ_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && $past(rd_en_o)) |-> (rd_idx_o == $past(rd_idx_o) - LOG_AW'(1))); // R3

    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_valid_o && !hw_ack_i) |=> (hw_valid_o && $stable(cur_addr_i))); // R6

    AST_INV_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_valid_o && hw_ack_i) |=> (inv_valid_o && inv_addr_o == $past(cur_addr_i))); // R7

    AST_DONE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!lock_o && !abort_o)); // R8

    AST_ABORT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (idx_count_i == '0 && !lock_o)); // R9

endmodule

// File: rtl/coalescing_replay_engine.sv
// Module: coalescing_replay_engine (top)
// Replays committed redo-log records to their home lines, coalescing
// writes per address and byte, and removes their mapping entries.
// Assumes: the log read port returns a record one cycle after rd_en_o,
// and the log is not modified while lock_o is high.
module coalescing_replay_engine #(
    parameter int ENTRIES    = 16,
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 8,
    parameter int LOG_AW     = 5,
    localparam int PTR_W     = $clog2(ENTRIES),
    localparam int CNT_W     = $clog2(ENTRIES + 1),
    localparam int DATA_W    = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  table_full_i,
    input  logic [LOG_AW:0]       log_count_i,
    output logic                  rd_en_o,
    output logic [LOG_AW-1:0]     rd_idx_o,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    input  logic [LINE_BYTES-1:0] rd_mask_i,
    input  logic [DATA_W-1:0]     rd_data_i,
    input  logic                  rd_commit_i,
    output logic                  hw_valid_o,
    output logic [ADDR_W-1:0]     hw_addr_o,
    output logic [LINE_BYTES-1:0] hw_mask_o,
    output logic [DATA_W-1:0]     hw_data_o,
    input  logic                  hw_ack_i,
    output logic                  inv_valid_o,
    output logic [ADDR_W-1:0]     inv_addr_o,
    output logic                  lock_o,
    output logic                  done_o,
    output logic                  abort_o
);

    logic             rec_pending;
    logic             idx_clear;
    logic             idx_upd;
    logic [CNT_W-1:0] idx_count;
    logic [PTR_W-1:0] wptr;

    // Only committed records reach the index
    assign idx_upd = rec_pending && rd_commit_i;

    lre_ctrl #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W),
        .LOG_AW  (LOG_AW)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .table_full_i  (table_full_i),
        .log_count_i   (log_count_i),
        .rd_en_o       (rd_en_o),
        .rd_idx_o      (rd_idx_o),
        .rec_pending_o (rec_pending),
        .idx_clear_o   (idx_clear),
        .idx_count_i   (idx_count),
        .wptr_o        (wptr),
        .cur_addr_i    (hw_addr_o),
        .hw_valid_o    (hw_valid_o),
        .hw_ack_i      (hw_ack_i),
        .inv_valid_o   (inv_valid_o),
        .inv_addr_o    (inv_addr_o),
        .lock_o        (lock_o),
        .done_o        (done_o),
        .abort_o       (abort_o)
    );

    lre_index #(
        .ENTRIES    (ENTRIES),
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_index (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (idx_clear),
        .upd_i      (idx_upd),
        .upd_addr_i (rd_addr_i),
        .upd_mask_i (rd_mask_i),
        .upd_data_i (rd_data_i),
        .sel_i      (wptr),
        .sel_addr_o (hw_addr_o),
        .sel_mask_o (hw_mask_o),
        .sel_data_o (hw_data_o),
        .count_o    (idx_count)
    );

    AST_UNCOMMITTED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_pending && !rd_commit_i) |=> $stable(idx_count)); // R5

endmodule

// File: tb/coalescing_replay_engine_test.sv
`timescale 1ns/1ps
module coalescing_replay_engine_test;

    typedef struct packed {
        logic [15:0] a;
        logic [7:0]  m;
        logic [63:0] d;
    } wr_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        table_full_i = 1'b0;
    logic [5:0]  log_count_i = '0;
    logic        rd_en_o;
    logic [4:0]  rd_idx_o;
    logic [15:0] rd_addr_i = '0;
    logic [7:0]  rd_mask_i = '0;
    logic [63:0] rd_data_i = '0;
    logic        rd_commit_i = 1'b0;
    logic        hw_valid_o;
    logic [15:0] hw_addr_o;
    logic [7:0]  hw_mask_o;
    logic [63:0] hw_data_o;
    logic        hw_ack_i = 1'b0;
    logic        inv_valid_o;
    logic [15:0] inv_addr_o;
    logic        lock_o;
    logic        done_o;
    logic        abort_o;

    int checks = 0;
    int errors = 0;

    // log model
    logic [15:0] lg_a [32];
    logic [7:0]  lg_m [32];
    logic [63:0] lg_d [32];
    logic        lg_c [32];
    int          lg_n = 0;

    wr_t exp_q[$];
    wr_t cap [32];
    wr_t prev_cap [32];
    int  cap_n = 0;
    int  prev_n = 0;
    int  exp_rd = 0;
    int  ack_lat = 0;
    int  ack_cnt = 0;
    bit  inv_due = 1'b0;
    logic [15:0] inv_exp = '0;
    bit  done_seen = 1'b0;
    bit  abort_seen = 1'b0;
    bit  rd_seen = 1'b0;

    always #5 clk = ~clk;

    coalescing_replay_engine uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .table_full_i(table_full_i),
        .log_count_i(log_count_i), .rd_en_o(rd_en_o), .rd_idx_o(rd_idx_o),
        .rd_addr_i(rd_addr_i), .rd_mask_i(rd_mask_i), .rd_data_i(rd_data_i),
        .rd_commit_i(rd_commit_i), .hw_valid_o(hw_valid_o), .hw_addr_o(hw_addr_o),
        .hw_mask_o(hw_mask_o), .hw_data_o(hw_data_o), .hw_ack_i(hw_ack_i),
        .inv_valid_o(inv_valid_o), .inv_addr_o(inv_addr_o), .lock_o(lock_o),
        .done_o(done_o), .abort_o(abort_o)
    );

    task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // log read port: one cycle of latency
    always @(posedge clk) begin
        if (rd_en_o) begin
            rd_addr_i   <= lg_a[rd_idx_o];
            rd_mask_i   <= lg_m[rd_idx_o];
            rd_data_i   <= lg_d[rd_idx_o];
            rd_commit_i <= lg_c[rd_idx_o];
        end
    end

    // home write acknowledge after ack_lat waiting cycles
    always @(posedge clk) begin
        if (hw_valid_o && !hw_ack_i) begin
            if (ack_cnt >= ack_lat) begin
                hw_ack_i <= 1'b1;
                ack_cnt  <= 0;
            end else begin
                ack_cnt <= ack_cnt + 1;
            end
        end else begin
            hw_ack_i <= 1'b0;
        end
    end

    // monitor: scoreboard pop and timing checks, away from the clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (inv_due) begin
                check(inv_valid_o && inv_addr_o == inv_exp, "R7 invalidate", {63'd0, inv_valid_o, inv_addr_o}, {63'd1, inv_exp});
            end else if (inv_valid_o) begin
                check(1'b0, "R7 stray invalidate", {64'd0, inv_addr_o}, 80'd0);
            end
            inv_due = 1'b0;
            if (rd_en_o) begin
                rd_seen = 1'b1;
                check(int'(rd_idx_o) == exp_rd, "R3 read order", {75'd0, rd_idx_o}, 80'(exp_rd));
                exp_rd--;
            end
            if (hw_valid_o && hw_ack_i) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected write", {64'd0, hw_addr_o}, 80'd0);
                end else begin
                    wr_t e;
                    e = exp_q.pop_front();
                    check(hw_addr_o == e.a, "R6 write address", {64'd0, hw_addr_o}, {64'd0, e.a});
                    check(hw_mask_o == e.m, "R4 write mask", {72'd0, hw_mask_o}, {72'd0, e.m});
                    check(hw_data_o == e.d, "R4 write data", {16'd0, hw_data_o}, {16'd0, e.d});
                end
                if (cap_n < 32) cap[cap_n] = '{hw_addr_o, hw_mask_o, hw_data_o};
                cap_n++;
                inv_due = 1'b1;
                inv_exp = hw_addr_o;
            end
            if (done_o) begin
                done_seen = 1'b1;
                check(!lock_o, "R8 lock low at done", {79'd0, lock_o}, 80'd0);
            end
            if (abort_o) begin
                abort_seen = 1'b1;
                check(!lock_o, "R2 lock low at abort", {79'd0, lock_o}, 80'd0);
            end
        end
    end

    task automatic set_rec(input int i, input logic [15:0] a, input logic [7:0] m,
                           input logic [63:0] d, input logic c);
        lg_a[i] = a; lg_m[i] = m; lg_d[i] = d; lg_c[i] = c;
    endtask

    // reference: newest-first coalescing into at most 16 lines
    task automatic build_expected();
        wr_t ex [16];
        int  n = 0;
        exp_q.delete();
        for (int i = lg_n - 1; i >= 0; i--) begin
            if (lg_c[i]) begin
                int hit = -1;
                for (int k = 0; k < n; k++) if (ex[k].a == lg_a[i]) hit = k;
                if (hit < 0 && n < 16) begin
                    hit = n;
                    ex[n] = '{lg_a[i], 8'h00, 64'd0};
                    n++;
                end
                if (hit >= 0) begin
                    for (int b = 0; b < 8; b++) begin
                        if (lg_m[i][b] && !ex[hit].m[b]) begin
                            ex[hit].d[b*8 +: 8] = lg_d[i][b*8 +: 8];
                            ex[hit].m[b] = 1'b1;
                        end
                    end
                end
            end
        end
        for (int k = 0; k < n; k++) exp_q.push_back(ex[k]);
    endtask

    // driver: push expectations, start a pass, wait for its status
    task automatic run_pass(input bit want_abort, input string tag);
        int wait_n = 0;
        build_expected();
        cap_n = 0;
        exp_rd = lg_n - 1;
        done_seen = 1'b0;
        abort_seen = 1'b0;
        log_count_i = 6'(lg_n);
        @(negedge clk);
        start_i = 1'b1;
        table_full_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(lock_o, {"R2 lock raised ", tag}, {79'd0, lock_o}, 80'd1);
        while (!done_seen && !abort_seen && wait_n < 3000) begin
            @(negedge clk);
            wait_n++;
        end
        table_full_i = 1'b0;
        check(abort_seen == want_abort, {"R9 abort status ", tag}, {79'd0, abort_seen}, {79'd0, want_abort});
        check(done_seen == !want_abort, {"R8 done status ", tag}, {79'd0, done_seen}, {79'd0, !want_abort});
        check(exp_q.size() == 0, {"R4 all lines written ", tag}, 80'(exp_q.size()), 80'd0);
        @(negedge clk);
        check(!lock_o, {"R2 lock released ", tag}, {79'd0, lock_o}, 80'd0);
    endtask

    function automatic bit addr_written(input logic [15:0] a);
        for (int k = 0; k < cap_n && k < 32; k++) if (cap[k].a == a) return 1'b1;
        return 1'b0;
    endfunction

    // watchdog
    initial begin
        #(1_000_000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!lock_o && !done_o && !abort_o && !hw_valid_o && !rd_en_o,
              "R2 reset state", {75'd0, lock_o, done_o, abort_o, hw_valid_o, rd_en_o}, 80'd0);

        // R1: start while the table is not full is ignored
        lg_n = 2;
        set_rec(0, 16'h0100, 8'hFF, 64'h1111_1111_1111_1111, 1'b1);
        set_rec(1, 16'h0200, 8'hFF, 64'h2222_2222_2222_2222, 1'b1);
        log_count_i = 6'd2;
        rd_seen = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        check(!lock_o && !rd_seen && !done_seen && !abort_seen, "R1 start ignored",
              {77'd0, lock_o, rd_seen, done_seen}, 80'd0);

        // R3/R6: three distinct committed lines, immediate ack
        ack_lat = 0;
        lg_n = 3;
        set_rec(0, 16'h0010, 8'hFF, 64'h0102_0304_0506_0708, 1'b1);
        set_rec(1, 16'h0020, 8'h0F, 64'hAAAA_AAAA_1122_3344, 1'b1);
        set_rec(2, 16'h0030, 8'h81, 64'h9900_0000_0000_0077, 1'b1);
        run_pass(1'b0, "basic");
        check(cap_n == 3, "R6 basic write count", 80'(cap_n), 80'd3);

        // R4/R5: coalescing across transactions, uncommitted skipped
        ack_lat = 2;
        lg_n = 5;
        set_rec(0, 16'h0A00, 8'h0F, 64'h0000_0000_A3A2_A1A0, 1'b1);
        set_rec(1, 16'h0B00, 8'hFF, 64'hB7B6_B5B4_B3B2_B1B0, 1'b1);
        set_rec(2, 16'h0A00, 8'h3C, 64'h0000_C5C4_C3C2_0000, 1'b1);
        set_rec(3, 16'h0A00, 8'hFF, 64'hDDDD_DDDD_DDDD_DDDD, 1'b0);
        set_rec(4, 16'h0C00, 8'hFF, 64'hEEEE_EEEE_EEEE_EEEE, 1'b0);
        run_pass(1'b0, "coalesce");
        check(cap_n == 2, "R4 coalesced write count", 80'(cap_n), 80'd2);
        check(cap[0].a == 16'h0A00 && cap[0].m == 8'h3F && cap[0].d == 64'h0000_C5C4_C3C2_A1A0,
              "R4 newest bytes win", cap[0], {16'h0A00, 8'h3F, 64'h0000_C5C4_C3C2_A1A0});
        check(!addr_written(16'h0C00), "R5 uncommitted-only line not written", 80'(addr_written(16'h0C00)), 80'd0);
        prev_n = cap_n;
        for (int k = 0; k < 32; k++) prev_cap[k] = cap[k];

        // R11: same log again gives the same writes
        ack_lat = 1;
        run_pass(1'b0, "rerun");
        check(cap_n == prev_n, "R11 rerun write count", 80'(cap_n), 80'(prev_n));
        for (int k = 0; k < prev_n; k++) begin
            check(cap[k] == prev_cap[k], "R11 rerun write match", cap[k], prev_cap[k]);
        end

        // R9: no committed record
        lg_n = 3;
        set_rec(0, 16'h0300, 8'hFF, 64'h1, 1'b0);
        set_rec(1, 16'h0400, 8'hFF, 64'h2, 1'b0);
        set_rec(2, 16'h0300, 8'h01, 64'h3, 1'b0);
        run_pass(1'b1, "uncommitted");
        check(cap_n == 0, "R9 no write on abort", 80'(cap_n), 80'd0);
        lg_n = 0;
        run_pass(1'b1, "empty");
        check(cap_n == 0, "R9 no write on empty log", 80'(cap_n), 80'd0);

        // R10: more distinct lines than index slots
        ack_lat = 0;
        lg_n = 20;
        for (int i = 0; i < 20; i++) begin
            set_rec(i, 16'h1000 + 16'(i), 8'(1 << (i % 8)), {8{8'(i + 8'h40)}}, 1'b1);
        end
        run_pass(1'b0, "overflow");
        check(cap_n == 16, "R10 capped write count", 80'(cap_n), 80'd16);
        check(!addr_written(16'h1000), "R10 oldest line skipped", 80'(addr_written(16'h1000)), 80'd0);
        check(addr_written(16'h1013), "R10 newest line kept", 80'(addr_written(16'h1013)), 80'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule